// File: doc/BRIEF.md
# Interval Timer Down-Counter Channel

One channel of a programmable interval timer. Software programs it through two byte-wide write strobes. One strobe carries a control byte and the other carries count data. The channel then counts down a 16-bit initial count, one step for each count tick, while its gate input is high.

When the count reaches zero, the `out` pin rises. It can serve directly as an interrupt request. Only the terminal-count interrupt mode is implemented. The count can run in plain binary or in four-digit BCD.

When the count hits zero, the counter does not stop. It wraps to its largest value and keeps going, while `out` stays high. `out` stays high until software writes a new control byte or a new count.

The block runs on a single system clock `clk`. The count clock is presented as a one-cycle enable `count_tick`, sampled on the rising edge of `clk`.

Top module: `pit_counter_chan`

## Requirements
- R1: After reset, `out` is low and the channel does not count. Data writes made before any control byte has been accepted are ignored.
- R2: A control byte is split into fields. Bits [7:6] select the channel and must equal `CHAN_ID` (default 0). Bits [5:4] set the byte access: 01 means low byte only, 10 means high byte only, 11 means low byte then high byte. Bits [3:1] must be 000. Bit 0 selects BCD counting when it is 1. A byte whose channel does not match, whose access field is 00 or whose mode field is not zero is ignored and changes nothing.
- R3: An accepted control byte drives `out` low on the next clock edge. It also halts counting and sets the data byte order back to the low byte. This holds even while the channel is counting or while `out` is high.
- R4: With access 11, the first data write supplies the low byte and the second supplies the high byte. The first write alone halts counting and drives `out` low; it does not start counting. The second write loads the count, and the first count tick after it performs the first decrement.
- R5: With access 01, a single write loads the count with the high byte set to zero. With access 10, a single write loads the count with the low byte set to zero.
- R6: Each count tick with `gate` high decrements the count by one in the selected base. With `gate` low, the count and `out` are held. A tick that arrives in the same cycle as a write does not decrement.
- R7: `out` rises on the tick that brings the count to zero. It then stays high until a control byte or a data write is accepted.
- R8: From zero, a decrement wraps to 0xFFFF in binary mode or to 9999 in BCD mode. Counting continues and `out` stays high.
- R9: A loaded count of zero gives the full range: `out` rises after 65536 ticks in binary mode and after 10000 ticks in BCD mode.
- R10: A BCD decrement borrows across all four digits, so 1000 becomes 0999. Loaded BCD counts must hold only digits 0 to 9, and the count then never holds a nibble above 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| count_tick | input | 1 | One-cycle count clock enable |
| gate | input | 1 | Counting enable; low suspends decrementing |
| cw_wr | input | 1 | Control byte write strobe |
| data_wr | input | 1 | Count data write strobe |
| wdata | input | 8 | Write data for either strobe |
| out | output | 1 | Terminal-count output, usable as interrupt request |

## Verification
The assertions assume that every BCD count loaded into the channel holds only decimal digits. They also assume that `count_tick` and the write strobes are qualified on the system clock edge. The digit-range property is only valid under the first of these. The bench honours both assumptions: it loads only well-formed BCD values, and it drives every strobe as a single-cycle pulse set up half a clock period before the edge that samples it. Expected tick counts are derived in the bench from the loaded bytes, by decoding them as decimal or binary numbers, and not from the design's decrement logic.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int DIGITS = CNT_W / 4;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_LOHI = 2'b11
  } access_e;

  // field order is what software encodes, so it is kept MSB first
  typedef struct packed {
    logic [1:0] chan;
    access_e    acc;
    logic [2:0] mode;
    logic       bcd;
  } ctrl_word_t;

  function automatic logic [CNT_W-1:0] dec_bin(input logic [CNT_W-1:0] v);
    return v - 1'b1;
  endfunction

  // digit-serial borrow chain; 0000 wraps to 9999
  function automatic logic [CNT_W-1:0] dec_bcd(input logic [CNT_W-1:0] v);
    logic [CNT_W-1:0] r;
    logic             borrow;
    logic [3:0]       nib;
    r      = v;
    borrow = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      nib = v[4*i +: 4];
      if (borrow) begin
        if (nib == 4'd0) begin
          nib = 4'd9;
        end else begin
          nib    = nib - 4'd1;
          borrow = 1'b0;
        end
      end
      r[4*i +: 4] = nib;
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] dec_step(input logic [CNT_W-1:0] v,
                                                input logic bcd);
    return bcd ? dec_bcd(v) : dec_bin(v);
  endfunction

  function automatic logic bcd_valid(input logic [CNT_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/pit_cw_decode.sv
module pit_cw_decode
  import pit_pkg::*;
#(
  parameter logic [1:0] CHAN_ID = 2'd0
) (
  input  logic              cw_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              cw_accept,
  output ctrl_word_t        cw
);
  logic chan_hit;
  logic acc_ok;
  logic mode_ok;

  always_comb begin
    cw        = ctrl_word_t'(wdata);
    chan_hit  = (cw.chan == CHAN_ID);
    acc_ok    = (cw.acc != ACC_NONE);
    mode_ok   = (cw.mode == 3'b000);
    cw_accept = cw_wr && chan_hit && acc_ok && mode_ok;
  end
endmodule

// File: rtl/pit_load_seq.sv
module pit_load_seq
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_accept,
  input  ctrl_word_t        cw,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              bcd_mode,
  output logic              load_strobe,
  output logic [CNT_W-1:0]  load_value,
  output logic              pause_strobe
);
  access_e           acc_q;
  logic              bcd_q;
  logic              hi_next_q;
  logic [BYTE_W-1:0] lo_q;
  logic              data_ok;

  assign bcd_mode = bcd_q;

  always_comb begin
    data_ok      = data_wr && !cw_accept && (acc_q != ACC_NONE);
    load_strobe  = 1'b0;
    pause_strobe = 1'b0;
    load_value   = '0;
    unique case (acc_q)
      ACC_LO: begin
        load_strobe = data_ok;
        load_value  = {{BYTE_W{1'b0}}, wdata};
      end
      ACC_HI: begin
        load_strobe = data_ok;
        load_value  = {wdata, {BYTE_W{1'b0}}};
      end
      ACC_LOHI: begin
        load_strobe  = data_ok && hi_next_q;
        pause_strobe = data_ok && !hi_next_q;
        load_value   = {wdata, lo_q};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= ACC_NONE;
      bcd_q     <= 1'b0;
      hi_next_q <= 1'b0;
      lo_q      <= '0;
    end else if (cw_accept) begin
      acc_q     <= cw.acc;
      bcd_q     <= cw.bcd;
      hi_next_q <= 1'b0;
    end else if (data_ok && acc_q == ACC_LOHI) begin
      hi_next_q <= !hi_next_q;
      if (!hi_next_q) lo_q <= wdata;
    end
  end
endmodule

// File: rtl/pit_down_core.sv
module pit_down_core
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_tick,
  input  logic             gate,
  input  logic             bcd_mode,
  input  logic             halt,
  input  logic             load_strobe,
  input  logic [CNT_W-1:0] load_value,
  output logic [CNT_W-1:0] cnt_q,
  output logic             running_q,
  output logic             out_q,
  output logic             term_hit
);
  logic             step_en;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    step_en  = running_q && count_tick && gate && !halt && !load_strobe;
    cnt_nxt  = dec_step(cnt_q, bcd_mode);
    term_hit = step_en && (cnt_nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
      out_q     <= 1'b0;
    end else if (load_strobe) begin
      cnt_q     <= load_value;
      running_q <= 1'b1;
      out_q     <= 1'b0;
    end else if (halt) begin
      running_q <= 1'b0;
      out_q     <= 1'b0;
    end else if (step_en) begin
      cnt_q <= cnt_nxt;
      if (term_hit) out_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pit_counter_chan.sv
module pit_counter_chan
  import pit_pkg::*;
#(
  parameter logic [1:0] CHAN_ID = 2'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       count_tick,
  input  logic       gate,
  input  logic       cw_wr,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  output logic       out
);
  ctrl_word_t       cw;
  logic             cw_accept;
  logic             bcd_mode;
  logic             load_strobe;
  logic             pause_strobe;
  logic [CNT_W-1:0] load_value;
  logic [CNT_W-1:0] cnt_value;
  logic             running;
  logic             term_hit;
  logic             halt;

  assign halt = cw_accept || pause_strobe;

  pit_cw_decode #(.CHAN_ID(CHAN_ID)) i_decode (
    .cw_wr     (cw_wr),
    .wdata     (wdata),
    .cw_accept (cw_accept),
    .cw        (cw)
  );

  pit_load_seq i_load (
    .clk          (clk),
    .rst_n        (rst_n),
    .cw_accept    (cw_accept),
    .cw           (cw),
    .data_wr      (data_wr),
    .wdata        (wdata),
    .bcd_mode     (bcd_mode),
    .load_strobe  (load_strobe),
    .load_value   (load_value),
    .pause_strobe (pause_strobe)
  );

  pit_down_core i_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .count_tick  (count_tick),
    .gate        (gate),
    .bcd_mode    (bcd_mode),
    .halt        (halt),
    .load_strobe (load_strobe),
    .load_value  (load_value),
    .cnt_q       (cnt_value),
    .running_q   (running),
    .out_q       (out),
    .term_hit    (term_hit)
  );
endmodule

// File: rtl/pit_counter_chkr.sv
module pit_counter_chkr
  import pit_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             count_tick,
  input logic             gate,
  input logic             out,
  input logic             cw_accept,
  input logic             pause_strobe,
  input logic             load_strobe,
  input logic             term_hit,
  input logic             running,
  input logic             bcd_mode,
  input logic [CNT_W-1:0] cnt_value
);
  logic quiet;
  assign quiet = !cw_accept && !pause_strobe && !load_strobe;

  a_r3_cw_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    cw_accept |=> !out);

  a_r7_out_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (out && quiet) |=> out);

  a_r7_rise_at_term: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out) |-> $past(term_hit));

  a_r6_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !gate && quiet) |=> $stable(cnt_value));

  a_r8_wrap_value: assert property (@(posedge clk) disable iff (!rst_n)
    (running && count_tick && gate && quiet && cnt_value == '0)
      |=> cnt_value == ($past(bcd_mode) ? 16'h9999 : 16'hFFFF));

  a_r10_bcd_digits: assert property (@(posedge clk) disable iff (!rst_n)
    (running && bcd_mode) |-> bcd_valid(cnt_value));

  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !out);
endmodule

bind pit_counter_chan pit_counter_chkr i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .count_tick   (count_tick),
  .gate         (gate),
  .out          (out),
  .cw_accept    (cw_accept),
  .pause_strobe (pause_strobe),
  .load_strobe  (load_strobe),
  .term_hit     (term_hit),
  .running      (running),
  .bcd_mode     (bcd_mode),
  .cnt_value    (cnt_value)
);

// File: tb/test_pit_counter_chan.sv
module test_pit_counter_chan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       count_tick = 1'b0;
  logic       gate = 1'b1;
  logic       cw_wr = 1'b0;
  logic       data_wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pit_counter_chan i_pit_counter_chan (
    .clk(clk), .rst_n(rst_n), .count_tick(count_tick), .gate(gate),
    .cw_wr(cw_wr), .data_wr(data_wr), .wdata(wdata), .out(out)
  );

  task automatic chk(input string tag, input logic exp);
    n_checks++;
    if (out !== exp) begin
      n_fail++;
      $display("FAIL %s: out=%0b expected %0b at %0t", tag, out, exp, $time);
    end
  endtask

  task automatic put_cw(input logic [7:0] b);
    cw_wr = 1'b1; wdata = b;
    @(negedge clk);
    cw_wr = 1'b0;
  endtask

  task automatic put_data(input logic [7:0] b);
    data_wr = 1'b1; wdata = b;
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      count_tick = 1'b1;
      repeat (n) @(negedge clk);
      count_tick = 1'b0;
    end
  endtask

  // bench-side meaning of a 16-bit count: decimal digits or binary, 0 = full range
  function automatic int span(input logic [15:0] v, input bit bcd);
    int r;
    if (bcd) r = v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
    else     r = v;
    if (r == 0) r = bcd ? 10000 : 65536;
    return r;
  endfunction

  task automatic expect_fire(input int n, input string tag);
    ticks(n - 1);
    chk(tag, 1'b0);
    ticks(1);
    chk(tag, 1'b1);
  endtask

  task automatic t_reset;
    chk("R1 reset out", 1'b0);
    put_data(8'h02);
    ticks(5);
    chk("R1 data before control ignored", 1'b0);
  endtask

  task automatic t_binary;
    put_cw(8'h30);
    chk("R3 control drops out", 1'b0);
    put_data(8'h05); put_data(8'h00);
    chk("R4 loaded, not yet fired", 1'b0);
    expect_fire(span(16'h0005, 0), "R6 R7 binary count 5");
    ticks(300);
    chk("R8 wrap keeps out high", 1'b1);
  endtask

  task automatic t_low_only;
    put_cw(8'h30);
    put_data(8'h03);
    ticks(10);
    chk("R4 low byte alone does not count", 1'b0);
    put_data(8'h00);
    expect_fire(3, "R4 count after high byte");
    put_data(8'h09);
    chk("R7 first byte write drops out", 1'b0);
    put_data(8'h00);
    expect_fire(9, "R4 reload 9");
  endtask

  task automatic t_gate;
    put_cw(8'h30);
    put_data(8'h04); put_data(8'h00);
    ticks(1);
    gate = 1'b0;
    ticks(20);
    chk("R6 gate low holds", 1'b0);
    gate = 1'b1;
    expect_fire(3, "R6 resume after gate");
  endtask

  task automatic t_rewrite;
    put_cw(8'h30);
    put_data(8'h02); put_data(8'h00);
    ticks(2);
    chk("R7 fired", 1'b1);
    put_cw(8'h30);
    chk("R3 rewrite drops out", 1'b0);
    ticks(70);
    chk("R3 halted after rewrite", 1'b0);
    put_data(8'h06); put_data(8'h00);
    ticks(3);
    put_cw(8'h30);
    ticks(10);
    chk("R3 rewrite mid-count halts", 1'b0);
  endtask

  task automatic t_ignored;
    put_cw(8'h30);
    put_data(8'h03); put_data(8'h00);
    ticks(1);
    put_cw(8'h70);
    put_cw(8'h32);
    put_cw(8'h00);
    expect_fire(2, "R2 foreign channel/mode/latch ignored");
  endtask

  task automatic t_single_byte;
    put_cw(8'h10);
    put_data(8'h07);
    expect_fire(7, "R5 low byte only");
    put_cw(8'h20);
    put_data(8'h01);
    expect_fire(256, "R5 high byte only");
  endtask

  task automatic t_bcd;
    put_cw(8'h31);
    put_data(8'h10); put_data(8'h00);
    expect_fire(span(16'h0010, 1), "R6 BCD 10");
    put_data(8'h00); put_data(8'h10);
    expect_fire(span(16'h1000, 1), "R10 BCD 1000 borrow");
  endtask

  task automatic t_full;
    put_cw(8'h30);
    put_data(8'h00); put_data(8'h00);
    expect_fire(span(16'h0000, 0), "R9 binary zero");
    ticks(10);
    chk("R8 wrap after full binary", 1'b1);
    put_cw(8'h31);
    put_data(8'h00); put_data(8'h00);
    expect_fire(span(16'h0000, 1), "R9 BCD zero");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_binary();
    t_low_only();
    t_gate();
    t_rewrite();
    t_ignored();
    t_single_byte();
    t_bcd();
    t_full();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule